// File: doc/BRIEF.md
# Packed Colour Lookup Table

This block is a 256-entry colour lookup table for a display pipeline. Software fills it through a 128-word bus window. Each 32-bit word holds two 16-bit entries. Each entry has three 5-bit colour fields and a flag bit that plays no part in the colour. Only the raw words are kept. A bus read of a window address returns the word exactly as it was last written.

The pixel unpacker presents an 8-bit colour index every cycle. One clock later the block returns the selected entry as a 24-bit colour. Each 5-bit field is widened to 8 bits by appending three zero bits. Writes that fall outside the window are dropped, and reads outside it return zero.

Top module: `clut_packed`

## Requirements
- R1: While reset is held, every table word is cleared to zero and both outputs are zero. After release, every read and lookup returns zero until a word is written.
- R2: A write with `wr_addr` in 0x200..0x3FF stores `wr_data` in word `(wr_addr-0x200)>>2`. A later read of that address returns the 32-bit word unchanged, in the cycle after `rd_en` is sampled.
- R3: A write with `wr_addr` outside 0x200..0x3FF changes no table word.
- R4: A read with `rd_addr` outside 0x200..0x3FF returns zero in the following cycle.
- R5: Word n supplies entry 2n from bits 15:0 and entry 2n+1 from bits 31:16. This holds up to the last word, n = 127.
- R6: In an entry, bits 4:0 map to `lk_rgb[7:3]`, bits 9:5 to `lk_rgb[15:11]` and bits 14:10 to `lk_rgb[23:19]`. Bits 2:0 of each output byte are zero.
- R7: Bit 15 of an entry has no effect on the colour returned for that entry.
- R8: `lk_rgb` shows the colour for the `lk_idx` sampled at the previous clock edge. A new index can be given every cycle.
- R9: When a lookup and a write to the word holding that entry happen in the same cycle, the lookup returns the old colour. A lookup in the next cycle returns the new colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 12 | Bus write byte offset |
| wr_data | input | 32 | Bus write data (two packed entries) |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 12 | Bus read byte offset |
| rd_data | output | 32 | Raw word read back, one cycle after `rd_en` |
| lk_idx | input | 8 | Colour index from the pixel unpacker |
| lk_rgb | output | 24 | Widened colour, one cycle after `lk_idx` |

## Verification
The bench builds the block with its default parameters: an 8-bit index and a 12-bit byte offset with the window at 0x200. With these values the whole 128-word window can be swept, including word 127 and entry 255. Addresses just below the window, at 0x400 and at the top of the offset space can all be tried. A same-cycle write and lookup of one word shows the read-before-write ordering.

// File: rtl/clut_packed.sv
module clut_packed #(
  parameter int IDX_W    = 8,
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [23:0]       lk_rgb
);
  localparam int WORD_W = IDX_W - 1;
  localparam int WORDS  = 2 ** WORD_W;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WORDS * 4);

  logic [31:0] mem [WORDS];

  logic [ADDR_W-1:0] wr_off, rd_off;
  logic              wr_hit, rd_hit;
  logic [WORD_W-1:0] wr_idx, rd_idx;
  logic [31:0]       lk_word;
  logic [15:0]       lk_half;

  assign wr_off  = wr_addr - BASE_A;
  assign rd_off  = rd_addr - BASE_A;
  assign wr_hit  = wr_off < SPAN_A;
  assign rd_hit  = rd_off < SPAN_A;
  assign wr_idx  = wr_off[WORD_W+1:2];
  assign rd_idx  = rd_off[WORD_W+1:2];
  assign lk_word = mem[lk_idx[IDX_W-1:1]];
  assign lk_half = lk_idx[0] ? lk_word[31:16] : lk_word[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rd_data <= '0;
      lk_rgb  <= '0;
    end else begin
      if (wr_en && wr_hit) mem[wr_idx] <= wr_data;
      if (rd_en) rd_data <= rd_hit ? mem[rd_idx] : '0;
      lk_rgb <= {lk_half[14:10], 3'b000, lk_half[9:5], 3'b000, lk_half[4:0], 3'b000};
    end
  end
endmodule

// File: rtl/clut_packed_chk.sv
module clut_packed_chk #(
  parameter int IDX_W    = 8,
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [23:0]       lk_rgb
);
  localparam int WORD_W = IDX_W - 1;
  localparam int LO = WIN_BASE;
  localparam int HI = WIN_BASE + 4 * (2 ** WORD_W);

  function automatic logic [23:0] widen(input logic [31:0] w, input logic hi);
    logic [15:0] e;
    e = hi ? w[31:16] : w[15:0];
    return {e[14:10], 3'b0, e[9:5], 3'b0, e[4:0], 3'b0};
  endfunction

  logic w_in, r_in;
  logic [WORD_W-1:0] w_word;
  assign w_in   = (int'(wr_addr) >= LO) && (int'(wr_addr) < HI);
  assign r_in   = (int'(rd_addr) >= LO) && (int'(rd_addr) < HI);
  assign w_word = WORD_W'((int'(wr_addr) - LO) >> 2);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lk_rgb == '0 && rd_data == '0));

  // R2
  raw_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_in) ##1 (rd_en && !wr_en && rd_addr == $past(wr_addr))
    |=> rd_data == $past(wr_data, 2));

  // R4
  outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !r_in) |=> rd_data == '0);

  // R5
  entry_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_in) ##1 (!wr_en && lk_idx[IDX_W-1:1] == $past(w_word))
    |=> lk_rgb == widen($past(wr_data, 2), $past(lk_idx[0])));

  // R6
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rgb[2:0] == 3'b0 && lk_rgb[10:8] == 3'b0 && lk_rgb[18:16] == 3'b0);
endmodule

bind clut_packed clut_packed_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
);

// File: tb/clut_packed_bench.sv
module clut_packed_bench;
  localparam int CLK_T = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  lk_idx = 0;
  logic [31:0] rd_data;
  logic [23:0] lk_rgb;

  int checks = 0, errors = 0;
  logic [31:0] model [128];

  bit          q_crd[$];
  logic [31:0] q_erd[$];
  bit          q_clk[$];
  logic [23:0] q_elk[$];
  string       q_tag[$];

  clut_packed u_clut_packed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  always #(CLK_T/2) clk = ~clk;

  function automatic bit in_win(input logic [11:0] a);
    return a >= 12'h200 && a <= 12'h3FF;
  endfunction

  function automatic logic [23:0] colour(input int idx);
    logic [15:0] e;
    logic [31:0] w;
    w = model[idx / 2];
    e = (idx % 2 == 1) ? w[31:16] : w[15:0];
    return {e[14:10], 3'b000, e[9:5], 3'b000, e[4:0], 3'b000};
  endfunction

  task automatic cyc(input bit we, input logic [11:0] wa, input logic [31:0] wd,
                     input bit re, input logic [11:0] ra, input logic [7:0] li,
                     input bit chk_lk, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra; lk_idx = li;
    q_crd.push_back(re);
    q_erd.push_back(in_win(ra) ? model[(ra - 12'h200) >> 2] : 32'h0);
    q_clk.push_back(chk_lk);
    q_elk.push_back(colour(int'(li)));
    q_tag.push_back(tag);
    if (we && in_win(wa)) model[(wa - 12'h200) >> 2] = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      bit cr, cl;
      logic [31:0] er;
      logic [23:0] el;
      string t;
      cr = q_crd.pop_front(); er = q_erd.pop_front();
      cl = q_clk.pop_front(); el = q_elk.pop_front(); t = q_tag.pop_front();
      if (cr) begin
        checks++;
        if (rd_data !== er) begin
          errors++;
          $display("FAIL %s read: got %h expected %h", t, rd_data, er);
        end
      end
      if (cl) begin
        checks++;
        if (lk_rgb !== el) begin
          errors++;
          $display("FAIL %s lookup: got %h expected %h", t, lk_rgb, el);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 0 || lk_rgb !== 0) begin
      errors++;
      $display("FAIL R1 in reset: got %h/%h expected 0/0", rd_data, lk_rgb);
    end
    rst_n = 1;
    // R1: nothing written yet
    cyc(0, 0, 0, 1, 12'h200, 8'd0, 1, "R1");
    cyc(0, 0, 0, 1, 12'h3FC, 8'd255, 1, "R1");
    // R2 / R5 / R6
    cyc(1, 12'h200, 32'h4321_7C1F, 0, 0, 0, 0, "w");
    cyc(0, 0, 0, 1, 12'h200, 8'd0, 1, "R2 R6");
    cyc(0, 0, 0, 0, 0, 8'd1, 1, "R5");
    // R7: flag bit ignored
    cyc(1, 12'h214, 32'h8000_FFFF, 0, 0, 0, 0, "w");
    cyc(1, 12'h218, 32'h0000_7FFF, 0, 0, 8'd10, 1, "R7");
    cyc(0, 0, 0, 1, 12'h214, 8'd12, 1, "R7");
    cyc(0, 0, 0, 0, 0, 8'd11, 1, "R7");
    // R3: writes outside the window
    cyc(1, 12'h000, 32'hFFFF_FFFF, 0, 0, 0, 0, "w");
    cyc(1, 12'h1FC, 32'hFFFF_FFFF, 0, 0, 0, 0, "w");
    cyc(1, 12'h400, 32'hFFFF_FFFF, 0, 0, 0, 0, "w");
    cyc(1, 12'hFFC, 32'hFFFF_FFFF, 0, 0, 0, 0, "w");
    cyc(0, 0, 0, 1, 12'h200, 8'd0, 1, "R3");
    cyc(0, 0, 0, 1, 12'h3FC, 8'd255, 1, "R3");
    cyc(0, 0, 0, 0, 0, 8'd1, 1, "R3");
    // R4: reads outside the window
    cyc(0, 0, 0, 1, 12'h1FC, 0, 0, "R4");
    cyc(0, 0, 0, 1, 12'h400, 0, 0, "R4");
    cyc(0, 0, 0, 1, 12'h000, 0, 0, "R4");
    // R5: last word
    cyc(1, 12'h3FC, 32'h1234_5678, 0, 0, 0, 0, "w");
    cyc(0, 0, 0, 1, 12'h3FC, 8'd254, 1, "R5 last");
    cyc(0, 0, 0, 0, 0, 8'd255, 1, "R5 last");
    // R9: same-cycle write and lookup
    cyc(1, 12'h20C, 32'h0BAD_F00D, 0, 0, 8'd6, 1, "R9 old");
    cyc(1, 12'h20C, 32'h5555_AAAA, 0, 0, 8'd6, 1, "R9 new");
    cyc(0, 0, 0, 0, 0, 8'd7, 1, "R9 new");
    // sweep all words, then all entries back to back (R8)
    for (int i = 0; i < 128; i++)
      cyc(1, 12'(12'h200 + 4 * i), 32'h9E37_79B9 * 32'(i + 1) ^ 32'(i), 0, 0, 0, 0, "w");
    for (int i = 0; i < 128; i++) cyc(0, 0, 0, 1, 12'(12'h200 + 4 * i), 0, 0, "R2");
    for (int i = 0; i < 256; i++) cyc(0, 0, 0, 0, 0, 8'(i), 1, "R8");
    for (int i = 255; i >= 0; i -= 3) cyc(0, 0, 0, 0, 0, 8'(i), 1, "R8");
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule